// File: doc/BRIEF.md
# Fractional Reference Tick Divider

This block turns a fast peripheral clock into a timing strobe for a real-time-clock counter. The strobe averages exactly 32,768 pulses per second. Software programs a divide ratio in two parts. The whole part is the integer value, equal to floor(f_clk / 32768) - 1. The fraction is the fractional value, equal to f_clk mod 32768, in the range 0 to 32,767.

Each output period normally lasts integer + 1 input cycles. At the end of each period the fraction is added to a 15-bit accumulator, modulo 32,768. When that add carries out, the period is extended by one input cycle. The extra cycles are therefore spread evenly rather than gathered in one place. Over every run of 32,768 periods, the extensions add exactly as many cycles as the fraction.

A write to either ratio register restarts the current period and clears the accumulator. An enable input freezes the divider while it is low.

Top module: `frac_tick_divider`

## Requirements
- R1: After reset, `tick_o` is low, `int_rdata_o` reads 1 and `frac_rdata_o` reads 0.
- R2: A write strobe stores its data, which appears on the matching read port after the next clock edge. Written integer values are at least 1.
- R3: With a fractional value of 0, every period between ticks lasts exactly integer + 1 enabled cycles.
- R4: Every period lasts either integer + 1 or integer + 2 enabled cycles, and an extension is exactly one cycle.
- R5: After a write, the first 32,768 × (integer + 1) + fractional enabled cycles contain exactly 32,768 ticks.
- R6: `tick_o` is high for one clock cycle per period and is never high on two consecutive cycles.
- R7: While `en_i` is low, no tick is produced and the position within the period is held. After the enable returns, the remaining cycles of that period complete as normal.
- R8: A write to either ratio register restarts the period and clears the accumulator. The next tick comes integer + 1 cycles later (plus one if the first period carries), counted with the new values.
- R9: Counting periods from k = 1 after a write, period k is extended exactly when floor(k·F/32768) > floor((k−1)·F/32768), where F is the fractional value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider run enable |
| int_wr_i | input | 1 | Write strobe for the integer value |
| int_wdata_i | input | 13 | New integer value (minimum 1) |
| frac_wr_i | input | 1 | Write strobe for the fractional value |
| frac_wdata_i | input | 15 | New fractional value |
| int_rdata_o | output | 13 | Current integer value |
| frac_rdata_o | output | 15 | Current fractional value |
| tick_o | output | 1 | One-cycle tick strobe |

## Verification
The assertions assume the integer value is never programmed to 0. With a zero integer value, a period could be a single cycle, and the strobe would no longer be a one-cycle pulse separated by idle cycles. The assertion on the integer write port turns this assumption into a check. Every write in the stimulus uses integer values of 1 or more, including the minimum value 1 in the long counting run. The enable is changed only between clock edges, and writes are issued only as one-cycle strobes, so each restart is a single event.

// File: rtl/presc_pkg.sv
package presc_pkg;

    // Phase of the current output period.
    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_EXTRA = 1'b1
    } phase_e;

    localparam int unsigned TICKS_PER_SEC = 32768;

endpackage

// File: rtl/presc_cfg.sv
module presc_cfg #(
    parameter int unsigned INT_W     = 13,
    parameter int unsigned FRAC_W    = 15,
    parameter int unsigned INT_RESET = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    output logic [INT_W-1:0]  int_val_o,
    output logic [FRAC_W-1:0] frac_val_o,
    output logic [INT_W-1:0]  int_next_o,
    output logic              restart_o
);

    typedef struct packed {
        logic [INT_W-1:0]  int_val;
        logic [FRAC_W-1:0] frac_val;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (int_wr) begin
            cfg_d.int_val = int_wdata;
        end
        if (frac_wr) begin
            cfg_d.frac_val = frac_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.int_val  <= INT_W'(INT_RESET);
            cfg_q.frac_val <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign int_val_o  = cfg_q.int_val;
    assign frac_val_o = cfg_q.frac_val;
    assign int_next_o = cfg_d.int_val;
    assign restart_o  = int_wr | frac_wr;

    assert_int_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr |-> (int_wdata != '0));

    assert_int_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr |=> (int_val_o == $past(int_wdata)));

    assert_frac_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frac_wr |=> (frac_val_o == $past(frac_wdata)));

endmodule

// File: rtl/presc_int_cnt.sv
module presc_int_cnt #(
    parameter int unsigned INT_W     = 13,
    parameter int unsigned INT_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             reload,
    input  logic [INT_W-1:0] load_val,
    output logic             cnt_zero_o
);

    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = load_val;
        end else if (en) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - INT_W'(1);
            end else if (reload) begin
                st_d.cnt = load_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= INT_W'(INT_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_zero_o = (st_q.cnt == '0);

    assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(st_q.cnt));

    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == $past(load_val)));

endmodule

// File: rtl/presc_frac_acc.sv
module presc_frac_acc #(
    parameter int unsigned FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_val,
    output logic              carry_o
);

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.acc} + {1'b0, frac_val};
        st_d = st_q;
        if (restart) begin
            st_d.acc = '0;
        end else if (step) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_o = sum[FRAC_W];

    assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.acc == '0));

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step) |=> $stable(st_q.acc));

endmodule

// File: rtl/frac_tick_divider.sv
module frac_tick_divider #(
    parameter int unsigned INT_W     = 13,
    parameter int unsigned FRAC_W    = 15,
    parameter int unsigned INT_RESET = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              int_wr_i,
    input  logic [INT_W-1:0]  int_wdata_i,
    input  logic              frac_wr_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    output logic [INT_W-1:0]  int_rdata_o,
    output logic [FRAC_W-1:0] frac_rdata_o,
    output logic              tick_o
);

    import presc_pkg::*;

    typedef struct packed {
        phase_e phase;
        logic   tick;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [INT_W-1:0]  int_val;
    logic [FRAC_W-1:0] frac_val;
    logic [INT_W-1:0]  int_next;
    logic              restart;
    logic              cnt_zero;
    logic              carry;
    logic              step;
    logic              period_end;

    presc_cfg #(
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .INT_RESET(INT_RESET)
    ) i_cfg (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .int_wr    (int_wr_i),
        .int_wdata (int_wdata_i),
        .frac_wr   (frac_wr_i),
        .frac_wdata(frac_wdata_i),
        .int_val_o (int_val),
        .frac_val_o(frac_val),
        .int_next_o(int_next),
        .restart_o (restart)
    );

    presc_int_cnt #(
        .INT_W    (INT_W),
        .INT_RESET(INT_RESET)
    ) i_int_cnt (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .en        (en_i),
        .restart   (restart),
        .reload    (period_end),
        .load_val  (int_next),
        .cnt_zero_o(cnt_zero)
    );

    presc_frac_acc #(
        .FRAC_W(FRAC_W)
    ) i_frac_acc (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .restart (restart),
        .step    (step),
        .frac_val(frac_val),
        .carry_o (carry)
    );

    always_comb begin
        step       = en_i && cnt_zero && (seq_q.phase == PH_RUN) && !restart;
        period_end = en_i && cnt_zero && !restart &&
                     ((seq_q.phase == PH_EXTRA) || !carry);

        seq_d      = seq_q;
        seq_d.tick = period_end;
        if (restart) begin
            seq_d.phase = PH_RUN;
        end else if (step && carry) begin
            seq_d.phase = PH_EXTRA;
        end else if (en_i && (seq_q.phase == PH_EXTRA)) begin
            seq_d.phase = PH_RUN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.phase <= PH_RUN;
            seq_q.tick  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tick_o       = seq_q.tick;
    assign int_rdata_o  = int_val;
    assign frac_rdata_o = frac_val;

    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    assert_no_tick_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !tick_o);

    assert_extra_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.phase == PH_EXTRA) |-> cnt_zero);

    assert_extra_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((seq_q.phase == PH_EXTRA) && en_i && !restart) |=> tick_o);

endmodule

// File: tb/test_frac_tick_divider.sv
module test_frac_tick_divider;

    localparam int INT_W  = 13;
    localparam int FRAC_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              int_wr = 1'b0;
    logic [INT_W-1:0]  int_wdata = '0;
    logic              frac_wr = 1'b0;
    logic [FRAC_W-1:0] frac_wdata = '0;
    logic [INT_W-1:0]  int_rdata;
    logic [FRAC_W-1:0] frac_rdata;
    logic              tick;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    frac_tick_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_frac_tick_divider (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .int_wr_i    (int_wr),
        .int_wdata_i (int_wdata),
        .frac_wr_i   (frac_wr),
        .frac_wdata_i(frac_wdata),
        .int_rdata_o (int_rdata),
        .frac_rdata_o(frac_rdata),
        .tick_o      (tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit carry_of(input longint k, input longint f);
        return ((k * f) >> 15) != (((k - 1) * f) >> 15);
    endfunction

    task automatic do_write(input bit wi, input int iv, input bit wf, input int fv);
        @(negedge clk);
        int_wr     = wi;
        int_wdata  = INT_W'(iv);
        frac_wr    = wf;
        frac_wdata = FRAC_W'(fv);
        @(negedge clk);
        int_wr  = 1'b0;
        frac_wr = 1'b0;
    endtask

    // Waits until the next tick; returns enabled cycles elapsed.
    task automatic next_period(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!tick && len < 100);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(tick == 1'b0, "R1", "tick after reset", tick, 0);
        chk(int_rdata == 1, "R1", "integer readback after reset", int_rdata, 1);
        chk(frac_rdata == 0, "R1", "fraction readback after reset", frac_rdata, 0);
    endtask

    task automatic t_readback;
        en = 1'b1;
        do_write(1, 1234, 1, 32767);
        chk(int_rdata == 1234, "R2", "integer readback", int_rdata, 1234);
        chk(frac_rdata == 32767, "R2", "fraction readback", frac_rdata, 32767);
        do_write(0, 0, 1, 777);
        chk(int_rdata == 1234, "R2", "integer kept on fraction write", int_rdata, 1234);
        chk(frac_rdata == 777, "R2", "fraction readback 2", frac_rdata, 777);
    endtask

    task automatic t_even;
        int len;
        int bad = 0;
        do_write(1, 4, 1, 0);
        for (int k = 1; k <= 10; k++) begin
            next_period(len);
            if (len != 5) bad++;
        end
        chk(bad == 0, "R3", "periods with zero fraction", bad, 0);
    endtask

    task automatic t_pattern(input int iv, input int fv, input int n);
        int len;
        int bad = 0;
        int first_bad = 0;
        int exp_len;
        do_write(1, iv, 1, fv);
        for (int k = 1; k <= n; k++) begin
            next_period(len);
            exp_len = iv + 1 + (carry_of(k, fv) ? 1 : 0);
            if (len != exp_len) begin
                if (bad == 0) first_bad = k;
                bad++;
            end
        end
        chk(bad == 0, "R9", "stretch placement mismatches", bad, 0);
        chk(first_bad == 0, "R4", "first wrong period index", first_bad, 0);
    endtask

    task automatic t_enable;
        int c = 0;
        do_write(1, 9, 1, 0);
        repeat (4) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) c++;
        end
        chk(c == 0, "R7", "ticks while disabled", c, 0);
        en = 1'b1;
        c  = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!tick && c < 100);
        chk(c == 6, "R7", "cycles left after re-enable", c, 6);
    endtask

    task automatic t_restart;
        int len;
        do_write(1, 5, 1, 0);
        repeat (3) @(negedge clk);
        do_write(1, 7, 0, 0);
        next_period(len);
        chk(len == 8, "R8", "first period after integer write", len, 8);
        do_write(1, 2, 1, 16384);
        next_period(len);
        chk(len == 3, "R8", "period 1 before rewrite", len, 3);
        repeat (2) @(negedge clk);
        do_write(0, 0, 1, 16384);
        next_period(len);
        chk(len == 3, "R8", "period 1 after fraction rewrite", len, 3);
        next_period(len);
        chk(len == 4, "R8", "period 2 after fraction rewrite", len, 4);
    endtask

    task automatic t_longrun(input int iv, input int fv);
        longint total;
        int ticks = 0;
        int c = 0;
        int bad_len = 0;
        int doubles = 0;
        bit prev = 1'b0;
        total = 64'(32768) * longint'(iv + 1) + longint'(fv);
        do_write(1, iv, 1, fv);
        for (longint n = 0; n < total; n++) begin
            @(negedge clk);
            c++;
            if (tick) begin
                ticks++;
                if (prev) doubles++;
                if (c != iv + 1 && c != iv + 2) bad_len++;
                c = 0;
            end
            prev = tick;
        end
        chk(ticks == 32768, "R5", "ticks in one averaging window", ticks, 32768);
        chk(bad_len == 0, "R4", "periods outside allowed lengths", bad_len, 0);
        chk(doubles == 0, "R6", "back-to-back ticks", doubles, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_even();
        t_pattern(2, 16384, 20);
        t_pattern(3, 12345, 40);
        t_enable();
        t_restart();
        t_longrun(1, 32767);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule